// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel flash device. After the host has written a program or erase command sequence, it starts this controller. The controller then reads the device status over a simple read request and acknowledge port, again and again. It stops when the status shows that the operation has finished, or that the device has accepted an erase suspend, or when a poll budget runs out.

Each run uses one of two detection methods, chosen at start. In data-polling mode the controller compares status bit 7 with the value the finished operation should leave there. For a program this is bit 7 of the programmed word; for an erase it is 1. In toggle mode it compares status bit 6 across two reads in a row: a bit that flips means the device is busy, and a bit that holds means it is finished or suspended. Every read goes to the address captured at start, so the address can be the programmed location or any location inside the block being erased.

The state machine has three states. IDLE waits for a start. READ holds the read request until it is acknowledged. EVAL judges the captured status. It has five named transitions:
- LAUNCH: IDLE to READ, taken on start.
- CAPTURE: READ to EVAL, taken on acknowledge.
- RETRY: EVAL to READ, taken when the operation is not finished and budget remains.
- FINISH: EVAL to IDLE, taken on completion or suspend.
- EXPIRE: EVAL to IDLE, taken when the budget is used up.

Top module: `flash_poll_ctrl`

## Requirements
- R1: Every read request carries on `rd_addr_o` the `tgt_addr_i` value captured when the run started. It holds that value for the whole run, even if `tgt_addr_i` changes.
- R2: Program run in data-polling mode (`op_erase_i`=0, `toggle_mode_i`=0): the run completes on the first read whose bit 7 equals bit 7 of `prog_data_i` captured at start. Other status bits are ignored.
- R3: Erase run in data-polling mode (`op_erase_i`=1, `toggle_mode_i`=0): the run completes on the first read whose bit 7 is 1.
- R4: Toggle mode (`toggle_mode_i`=1): the run completes on the first read whose bit 6 equals bit 6 of the read just before it. At least two reads are therefore needed, and bit 7 is ignored.
- R5: A `susp_req_i` pulse during an erase run makes the detection end with `suspended_o`=1 and no `done_o` pulse. During a program run the same pulse is ignored, and the run ends with `done_o`.
- R6: If the number of reads reaches the effective limit without completion, `timeout_o` rises, `busy_o` falls in the same cycle, and the controller returns to IDLE. The effective limit is `poll_limit_i` captured at start, and a value of 0 counts as 1.
- R7: `done_o` is high for exactly one cycle, and that is the cycle in which `busy_o` first reads 0. `suspended_o` and `timeout_o` stay set until the next start, which clears them.
- R8: After reset, `busy_o`, `done_o`, `suspended_o`, `timeout_o` and `rd_req_o` are all 0.
- R9: A `start_i` pulse while `busy_o`=1 is ignored: the address, the limit and the outcome of the current run do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| op_erase_i | input | 1 | 1 = erase run, 0 = program run |
| toggle_mode_i | input | 1 | 1 = toggle detection, 0 = data polling |
| tgt_addr_i | input | AW | Address to poll |
| prog_data_i | input | DW | Word written by the program command |
| poll_limit_i | input | CW | Maximum number of reads, where 0 counts as 1 |
| susp_req_i | input | 1 | Pulse: an erase suspend was issued |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, with valid `rd_data_i` |
| rd_data_i | input | DW | Status word read from the device |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse: operation finished |
| suspended_o | output | 1 | Erase suspend took effect |
| timeout_o | output | 1 | Poll budget exhausted |

## Verification
The bench builds the block with AW=12, DW=8 and CW=4. Limits from 0 to 15 are then reachable, so both ends of the poll budget get exercised: a limit of 0 acting as one read, and a full fifteen-read expiry on a bit 6 that never settles. The narrow data word keeps the status bits that do not matter random on every read. The device model adds a random acknowledge latency, so the request hold and the address stability are checked under waits.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EVAL = 2'd2
    } poll_state_e;
endpackage

// File: rtl/fpc_verdict.sv
module fpc_verdict #(
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic toggle_mode_i,
    input  logic expect_bit_i,
    input  logic poll_bit_i,
    input  logic tog_bit_i,
    input  logic prev_tog_i,
    input  logic have_prev_i,
    output logic complete_o
);
    localparam bit BITS_DISTINCT = (POLL_BIT != TOG_BIT);

    // Toggle: settled once two reads in a row agree.
    // Data poll: settled once bit 7 shows its final value.
    always_comb begin
        if (toggle_mode_i) begin
            complete_o = BITS_DISTINCT && have_prev_i && (tog_bit_i == prev_tog_i);
        end else begin
            complete_o = (poll_bit_i == expect_bit_i);
        end
    end
endmodule

// File: rtl/fpc_poll_budget.sv
module fpc_poll_budget #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] limit_i,
    input  logic          step_i,
    output logic          exhausted_o
);
    localparam logic [CW-1:0] ONE     = CW'(1);
    localparam logic [CW-1:0] ALL_SET = {CW{1'b1}};

    logic [CW-1:0] used_q;
    logic [CW-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
            cap_q  <= ONE;
        end else if (load_i) begin
            used_q <= '0;
            cap_q  <= (limit_i == '0) ? ONE : limit_i;
        end else if (step_i && (used_q != ALL_SET)) begin
            used_q <= used_q + ONE;
        end
    end

    assign exhausted_o = (used_q >= cap_q);
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int AW       = 22,
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          op_erase_i,
    input  logic          toggle_mode_i,
    input  logic [AW-1:0] tgt_addr_i,
    input  logic [DW-1:0] prog_data_i,
    input  logic [CW-1:0] poll_limit_i,
    input  logic          susp_req_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          suspended_o,
    output logic          timeout_o
);
    poll_state_e state_q, state_d;

    logic [AW-1:0] addr_q;
    logic          erase_q;
    logic          toggle_q;
    logic          expect_q;
    logic          susp_pend_q;
    logic          poll_bit_q;
    logic          tog_bit_q;
    logic          prev_tog_q;
    logic          have_prev_q;
    logic          complete;
    logic          exhausted;
    logic          launch;
    logic          capture;

    assign launch  = (state_q == ST_IDLE) && start_i;
    assign capture = (state_q == ST_READ) && rd_ack_i;

    fpc_verdict #(
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_verdict (
        .toggle_mode_i (toggle_q),
        .expect_bit_i  (expect_q),
        .poll_bit_i    (poll_bit_q),
        .tog_bit_i     (tog_bit_q),
        .prev_tog_i    (prev_tog_q),
        .have_prev_i   (have_prev_q),
        .complete_o    (complete)
    );

    fpc_poll_budget #(
        .CW (CW)
    ) u_budget (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (launch),
        .limit_i     (poll_limit_i),
        .step_i      (capture),
        .exhausted_o (exhausted)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)  state_d = ST_READ;   // LAUNCH
            ST_READ: if (rd_ack_i) state_d = ST_EVAL;   // CAPTURE
            ST_EVAL: begin
                if (complete || exhausted) state_d = ST_IDLE;  // FINISH / EXPIRE
                else                       state_d = ST_READ;  // RETRY
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Run context and captured status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            erase_q     <= 1'b0;
            toggle_q    <= 1'b0;
            expect_q    <= 1'b0;
            susp_pend_q <= 1'b0;
            poll_bit_q  <= 1'b0;
            tog_bit_q   <= 1'b0;
            prev_tog_q  <= 1'b0;
            have_prev_q <= 1'b0;
        end else begin
            if (launch) begin
                addr_q      <= tgt_addr_i;
                erase_q     <= op_erase_i;
                toggle_q    <= toggle_mode_i;
                expect_q    <= op_erase_i ? 1'b1 : prog_data_i[POLL_BIT];
                susp_pend_q <= 1'b0;
                have_prev_q <= 1'b0;
            end else if (susp_req_i && erase_q && (state_q != ST_IDLE)) begin
                susp_pend_q <= 1'b1;
            end
            if (capture) begin
                poll_bit_q <= rd_data_i[POLL_BIT];
                tog_bit_q  <= rd_data_i[TOG_BIT];
            end
            if ((state_q == ST_EVAL) && !complete) begin
                prev_tog_q  <= tog_bit_q;
                have_prev_q <= 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o      <= 1'b0;
            done_o      <= 1'b0;
            suspended_o <= 1'b0;
            timeout_o   <= 1'b0;
        end else begin
            busy_o <= (state_d != ST_IDLE);
            done_o <= (state_q == ST_EVAL) && complete && !susp_pend_q;
            if (launch) begin
                suspended_o <= 1'b0;
                timeout_o   <= 1'b0;
            end else if (state_q == ST_EVAL) begin
                if (complete && susp_pend_q)   suspended_o <= 1'b1;
                if (!complete && exhausted)    timeout_o   <= 1'b1;
            end
        end
    end

    assign rd_req_o  = (state_q == ST_READ);
    assign rd_addr_o = addr_q;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int AW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [AW-1:0] tgt_addr_i,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_ack_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          suspended_o,
    input logic          timeout_o
);
    logic [AW-1:0] seen_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  seen_addr <= '0;
        else if (start_i && !busy_o) seen_addr <= tgt_addr_i;
    end

    p_addr_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o == seen_addr));

    p_req_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_expire_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> !busy_o);

    p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, suspended_o, timeout_o}));

    p_req_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o);
endmodule

bind flash_poll_ctrl fpc_checker #(.AW(AW)) u_fpc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tgt_addr_i  (tgt_addr_i),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_ack_i    (rd_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .suspended_o (suspended_o),
    .timeout_o   (timeout_o)
);

// File: tb/flash_poll_ctrl_test.sv
`timescale 1ns/1ps
module flash_poll_ctrl_test;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_erase_i = 1'b0;
    logic          toggle_mode_i = 1'b0;
    logic [AW-1:0] tgt_addr_i = '0;
    logic [DW-1:0] prog_data_i = '0;
    logic [CW-1:0] poll_limit_i = '0;
    logic          susp_req_i = 1'b0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          busy_o, done_o, suspended_o, timeout_o;

    int checks = 0;
    int fails  = 0;

    // device model state
    bit            m_toggle;
    bit            m_exp;
    int            m_n;
    int            reads;
    int            wait_cnt;
    int            addr_bad;
    logic [AW-1:0] exp_addr;

    always #4 clk = ~clk;

    flash_poll_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .toggle_mode_i(toggle_mode_i), .tgt_addr_i(tgt_addr_i),
        .prog_data_i(prog_data_i), .poll_limit_i(poll_limit_i),
        .susp_req_i(susp_req_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .done_o(done_o), .suspended_o(suspended_o), .timeout_o(timeout_o)
    );

    function automatic logic [DW-1:0] model_word(input int i);
        logic [DW-1:0] w;
        w = DW'($urandom);
        if (m_toggle) w[6] = (i <= m_n) ? i[0] : m_n[0];
        else          w[7] = (i <= m_n) ? ~m_exp : m_exp;
        return w;
    endfunction

    function automatic int reads_needed(input bit tog, input int n);
        if (tog) return (n + 1 < 2) ? 2 : n + 1;
        return n + 1;
    endfunction

    function automatic int eff_limit(input int lim);
        return (lim == 0) ? 1 : lim;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            rd_ack_i = 1'b0;
        end else if (rd_ack_i) begin
            rd_ack_i = 1'b0;
        end else if (rd_req_o) begin
            if (rd_addr_o !== exp_addr) addr_bad++;
            if (wait_cnt == 0) begin
                reads++;
                rd_data_i = model_word(reads);
                rd_ack_i  = 1'b1;
                wait_cnt  = int'($urandom % 3);
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input bit erase, input bit tog, input int n, input int limit,
                       input bit susp, input bit restart);
        int    wd;
        int    need, lim, exp_reads;
        bit    exp_to, exp_susp, exp_done;
        string tag;
        logic [DW-1:0] pdata;
        pdata    = DW'($urandom);
        exp_addr = AW'($urandom);
        m_toggle = tog;
        m_exp    = erase ? 1'b1 : pdata[7];
        m_n      = n;
        reads    = 0;
        addr_bad = 0;
        wait_cnt = int'($urandom % 3);
        tag = tog ? "R4" : (erase ? "R3" : "R2");

        @(negedge clk);
        start_i = 1'b1; op_erase_i = erase; toggle_mode_i = tog;
        tgt_addr_i = exp_addr; prog_data_i = pdata; poll_limit_i = CW'(limit);
        @(negedge clk);
        start_i = 1'b0; tgt_addr_i = AW'($urandom);
        chk(busy_o === 1'b1, "R7 busy after start", int'(busy_o), 1);
        chk(timeout_o === 1'b0 && suspended_o === 1'b0, "R7 flags cleared by start",
            int'({timeout_o, suspended_o}), 0);
        if (susp) begin
            susp_req_i = 1'b1;
            @(negedge clk);
            susp_req_i = 1'b0;
        end
        if (restart) begin
            start_i = 1'b1; tgt_addr_i = ~exp_addr; poll_limit_i = '0;
            toggle_mode_i = ~tog;
            @(negedge clk);
            start_i = 1'b0;
        end
        wd = 0;
        while (busy_o === 1'b1 && wd < 2000) begin
            @(negedge clk);
            wd++;
        end
        chk(wd < 2000, "watchdog", wd, 0);

        lim       = eff_limit(limit);
        need      = reads_needed(tog, n);
        exp_to    = need > lim;
        exp_reads = exp_to ? lim : need;
        exp_susp  = !exp_to && susp && erase;
        exp_done  = !exp_to && !exp_susp;

        chk(done_o === exp_done, {tag, " done"}, int'(done_o), int'(exp_done));
        chk(reads == exp_reads, restart ? "R9 reads after ignored start" : {tag, " reads"},
            reads, exp_reads);
        chk(timeout_o === exp_to, "R6 timeout", int'(timeout_o), int'(exp_to));
        chk(suspended_o === exp_susp, "R5 suspended", int'(suspended_o), int'(exp_susp));
        chk(addr_bad == 0, restart ? "R9 address kept" : "R1 address", addr_bad, 0);
        @(negedge clk);
        chk(done_o === 1'b0, "R7 done one cycle", int'(done_o), 0);
        chk(timeout_o === exp_to && suspended_o === exp_susp, "R7 flags persist",
            int'({timeout_o, suspended_o}), int'({exp_to, exp_susp}));
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        exp_addr = '0;
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, suspended_o, timeout_o, rd_req_o} === 5'b0, "R8 reset state",
            int'({busy_o, done_o, suspended_o, timeout_o, rd_req_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, rd_req_o} === 2'b0, "R8 idle after reset", int'({busy_o, rd_req_o}), 0);

        run(1'b0, 1'b0, 0, 5, 1'b0, 1'b0);   // R2 first read matches
        run(1'b0, 1'b0, 3, 10, 1'b0, 1'b0);  // R2 a few busy reads
        run(1'b1, 1'b0, 2, 4, 1'b0, 1'b0);   // R3 erase data polling
        run(1'b0, 1'b1, 0, 4, 1'b0, 1'b0);   // R4 minimum of two reads
        run(1'b1, 1'b1, 5, 15, 1'b0, 1'b0);  // R4 long toggling erase
        run(1'b1, 1'b0, 2, 8, 1'b1, 1'b0);   // R5 suspend via bit 7
        run(1'b1, 1'b1, 1, 8, 1'b1, 1'b0);   // R5 suspend via bit 6
        run(1'b0, 1'b0, 1, 8, 1'b1, 1'b0);   // R5 ignored on program
        run(1'b0, 1'b0, 20, 0, 1'b0, 1'b0);  // R6 limit 0 acts as 1
        run(1'b0, 1'b1, 1, 1, 1'b0, 1'b0);   // R6 toggle cannot finish in 1 read
        run(1'b1, 1'b1, 30, 15, 1'b0, 1'b0); // R6 full budget expiry
        run(1'b0, 1'b0, 4, 10, 1'b0, 1'b1);  // R9 start while busy
        run(1'b1, 1'b0, 0, 3, 1'b0, 1'b0);   // R7 clears earlier timeout

        for (int k = 0; k < 40; k++) begin
            run(1'($urandom), 1'($urandom), int'($urandom % 8), int'($urandom % 16),
                1'($urandom), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule